// File: doc/BRIEF.md
# SPI Status-Register Command Controller

This block is the command front end of a serial memory slave. It watches a chip-select line and a serial clock, collects an 8-bit opcode per frame, and acts on the small set of commands that manage an 8-bit status register. The commands set and clear a write-enable latch, read the status register, write its configuration fields, and switch the link between one-bit and four-bit transfer. The status byte goes back to the host on the falling edge of the serial clock for as long as the host keeps clocking. Commands that write the array are only recognised, so that the latch can be cleared when their frame ends. The array itself lives elsewhere.

The serial inputs are not used as clocks. The block runs on a fast system clock, passes chip select, the serial clock and the four data lines through a short synchroniser, and acts on the edges it finds there. The host's serial clock must therefore stay well below the system clock. The bench uses eight system cycles per serial cycle. There is no data stream at the block's edge, so there is no valid/ready handshake. Every pin is plain control or data. Back-pressure comes only from the host, which may stop or stretch the serial clock at any point.

Top module: `spi_sr_ctrl`

## Requirements
- R1: After reset the status register reads 0x00. While chip select is high, all four output enables are 0.
- R2: Input bits are taken on the rising edge of the serial clock, MSB first. In one-bit mode they arrive on IO0, and the reply is driven on IO1, changing only after a falling edge.
- R3: The opcodes are 0x06 set-latch, 0x04 clear-latch, 0x05 read-status, 0x01 write-status, 0x38 enter-quad and 0xFF exit-quad. The write-class opcodes 0x02, 0x32 and 0x12 are also recognised.
- R4: The latch is status bit 1. Opcode 0x06 sets it and opcode 0x04 clears it, each when the opcode's last bit is taken.
- R5: Read-status returns the layout bit7 protect-enable, bit6 quad flag, bits5:4 latency, bits3:2 block-protect, bit1 latch, bit0 zero. The byte repeats for as long as the clock runs.
- R6: Write-status changes only bits 7, 5:4 and 3:2 (mask 0xBC). It commits at the chip-select rise, and only if the latch was 1 when the opcode was taken and a full data byte has arrived.
- R7: The latch clears at the chip-select rise that ends a frame whose opcode was 0x01, 0x02, 0x32 or 0x12, whether or not a write-status committed.
- R8: Opcode 0x38 sets bit 6 and 0xFF clears it, and write-status data never changes bit 6. While bit 6 is 1, each clock carries one nibble on IO3..IO0 with IO3 as MSB, and the high nibble comes first.
- R9: During the data phase of read-status the output enables are 0010 in one-bit mode and 1111 in quad mode. In every other phase they are 0000.
- R10: An opcode outside the list in R3 changes no status bit and drives no output until chip select rises.
- R11: A chip-select rise discards a partly received opcode, so the next frame starts decoding afresh.
- R12: Status bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| io_in | input | 4 | Sampled levels of IO3..IO0 |
| io_out | output | 4 | Values driven on IO3..IO0 |
| io_oe | output | 4 | Per-line output enable |

## Verification
The assertions take for granted that the host changes its inputs only with chip select and the serial clock at settled levels. They also assume each serial clock level lasts longer than the synchroniser depth, so that each edge is seen exactly once. The bench holds every level for four system cycles. It changes the data lines only while the serial clock is low, and it leaves a gap of several cycles between chip-select frames.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OP_SETLAT  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_CLRLAT  = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSTAT  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRSTAT  = 8'h01;
  localparam logic [BYTE_W-1:0] OP_QUADON  = 8'h38;
  localparam logic [BYTE_W-1:0] OP_QUADOFF = 8'hFF;
  localparam logic [BYTE_W-1:0] OP_WR1     = 8'h02;
  localparam logic [BYTE_W-1:0] OP_WR4     = 8'h32;
  localparam logic [BYTE_W-1:0] OP_WR4A    = 8'h12;
  localparam logic [BYTE_W-1:0] CFG_MASK   = 8'hBC;

  typedef enum logic [1:0] {PH_CMD, PH_READ, PH_WDATA, PH_SKIP} phase_e;
endpackage

// File: rtl/spi_sr_sampler.sv
module spi_sr_sampler #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic [3:0] io_in,
  output logic       sel,
  output logic       sck_rise,
  output logic       sck_fall,
  output logic       cs_rise,
  output logic [3:0] io_s
);
  localparam int PW = 6;
  localparam logic [PW-1:0] IDLE = 6'b100000;

  logic [PW-1:0] pipe [STAGES];
  logic [PW-1:0] prev;
  logic [PW-1:0] cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE;
      prev <= IDLE;
    end else begin
      pipe[0] <= {cs_n, sck, io_in};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign cur      = pipe[STAGES-1];
  assign sel      = ~cur[5];
  assign sck_rise = cur[4] & ~prev[4];
  assign sck_fall = ~cur[4] & prev[4];
  assign cs_rise  = cur[5] & ~prev[5];
  assign io_s     = cur[3:0];
endmodule

// File: rtl/spi_sr_status.sv
module spi_sr_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_lat,
  input  logic       clr_lat,
  input  logic       set_quad,
  input  logic       clr_quad,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] status
);
  logic       prot_en;
  logic       quad;
  logic [1:0] lat_ctl;
  logic [1:0] blk_prot;
  logic       wlatch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_en  <= 1'b0;
      quad     <= 1'b0;
      lat_ctl  <= 2'b00;
      blk_prot <= 2'b00;
      wlatch   <= 1'b0;
    end else begin
      if (wr_en) begin
        prot_en  <= wr_data[7];
        lat_ctl  <= wr_data[5:4];
        blk_prot <= wr_data[3:2];
      end
      if (set_quad)      quad <= 1'b1;
      else if (clr_quad) quad <= 1'b0;
      if (set_lat)       wlatch <= 1'b1;
      else if (clr_lat)  wlatch <= 1'b0;
    end
  end

  assign status = {prot_en, quad, lat_ctl, blk_prot, wlatch, 1'b0};

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({status[7], status[5:2]}));
  p_quad_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_quad || clr_quad) |=> $stable(status[6]));
  p_latch_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_lat |=> status[1]);
endmodule

// File: rtl/spi_sr_tx.sv
module spi_sr_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       sck_fall,
  input  logic       active,
  input  logic       quad,
  input  logic [7:0] status,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);
  logic [2:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n || !sel) begin
      ptr    <= 3'd0;
      io_out <= 4'h0;
      io_oe  <= 4'h0;
    end else if (sck_fall && active) begin
      if (quad) begin
        io_out <= ptr[2] ? status[3:0] : status[7:4];
        io_oe  <= 4'hF;
        ptr    <= ptr + 3'd4;
      end else begin
        io_out <= {2'b00, status[3'd7 - ptr], 1'b0};
        io_oe  <= 4'b0010;
        ptr    <= ptr + 3'd1;
      end
    end
  end

  p_oe_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe != 4'h0) |-> $past(active));
  p_oe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (io_oe == 4'h0));
endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl
  import spi_sr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic [3:0] io_in,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);
  localparam int CW = $clog2(BYTE_W) + 1;

  logic          sel, sck_rise, sck_fall, cs_rise;
  logic [3:0]    io_s;
  logic [7:0]    status;
  phase_e        phase;
  logic [7:0]    sh, nxt;
  logic [CW-1:0] cnt, cnt_n, step;
  logic          armed, full, wcls;
  logic          quad, wel;
  logic          shift_ev, byte_ev, op_ev, is_wcls;
  logic          set_lat, clr_lat, set_quad, clr_quad, wr_en;

  spi_sr_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_in(io_in),
    .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_rise(cs_rise), .io_s(io_s)
  );

  assign quad = status[6];
  assign wel  = status[1];

  always_comb begin
    step     = quad ? CW'(4) : CW'(1);
    cnt_n    = cnt + step;
    nxt      = quad ? {sh[3:0], io_s} : {sh[6:0], io_s[0]};
    shift_ev = sel && sck_rise && (phase == PH_CMD || phase == PH_WDATA);
    byte_ev  = shift_ev && (cnt_n == CW'(BYTE_W));
    op_ev    = byte_ev && (phase == PH_CMD);
    is_wcls  = (nxt == OP_WRSTAT) || (nxt == OP_WR1) ||
               (nxt == OP_WR4) || (nxt == OP_WR4A);
  end

  assign set_lat  = op_ev && (nxt == OP_SETLAT);
  assign clr_lat  = (op_ev && (nxt == OP_CLRLAT)) || (cs_rise && wcls);
  assign set_quad = op_ev && (nxt == OP_QUADON);
  assign clr_quad = op_ev && (nxt == OP_QUADOFF);
  assign wr_en    = cs_rise && armed && full;

  always_ff @(posedge clk) begin
    if (!rst_n || !sel) begin
      phase <= PH_CMD;
      cnt   <= '0;
      sh    <= '0;
      armed <= 1'b0;
      full  <= 1'b0;
      wcls  <= 1'b0;
    end else if (shift_ev) begin
      sh  <= nxt;
      cnt <= byte_ev ? '0 : cnt_n;
      if (op_ev) begin
        wcls <= is_wcls;
        if (nxt == OP_RDSTAT) phase <= PH_READ;
        else if (nxt == OP_WRSTAT) begin
          phase <= PH_WDATA;
          armed <= wel;
        end else phase <= PH_SKIP;
      end else if (byte_ev) begin
        full  <= 1'b1;
        phase <= PH_SKIP;
      end
    end
  end

  spi_sr_status u_st (
    .clk(clk), .rst_n(rst_n), .set_lat(set_lat), .clr_lat(clr_lat),
    .set_quad(set_quad), .clr_quad(clr_quad), .wr_en(wr_en),
    .wr_data(sh & CFG_MASK), .status(status)
  );

  spi_sr_tx u_tx (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_fall(sck_fall),
    .active(phase == PH_READ), .quad(quad), .status(status),
    .io_out(io_out), .io_oe(io_oe)
  );

  p_latch_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[1]) |-> $past(cs_rise || op_ev));
  p_commit_at_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable({status[7], status[5:2]}));
  p_bit0_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] == 1'b0);
endmodule

// File: tb/spi_sr_ctrl_test.sv
module spi_sr_ctrl_test;
  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic [3:0] io_in = 4'h0;
  logic [3:0] io_out, io_oe;
  logic       qm = 1'b0;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  spi_sr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] v, output logic [3:0] r, output logic [3:0] oe);
    io_in = v;
    repeat (H) @(negedge clk);
    r  = io_out;
    oe = io_oe;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits,
                      output logic [7:0] rx, output logic [3:0] oe0);
    logic [3:0] r, oe;
    rx = 8'h00;
    if (qm) begin
      for (int i = 0; i < 2; i++) begin
        step(i == 0 ? tx[7:4] : tx[3:0], r, oe);
        if (i == 0) oe0 = oe;
        rx = {rx[3:0], r};
      end
    end else begin
      for (int i = 0; i < nbits; i++) begin
        step({3'b000, tx[7-i]}, r, oe);
        if (i == 0) oe0 = oe;
        rx = {rx[6:0], r[1]};
      end
    end
  endtask

  task automatic frame_open();
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic frame_close();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (H + 4) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] rx; logic [3:0] oe;
    frame_open(); xfer(op, 8, rx, oe); frame_close();
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [7:0] rx; logic [3:0] oe;
    frame_open(); xfer(8'h01, 8, rx, oe); xfer(d, 8, rx, oe); frame_close();
  endtask

  task automatic rdsr(output logic [7:0] v, output logic [3:0] oe_op, output logic [3:0] oe_dat);
    logic [7:0] rx;
    frame_open(); xfer(8'h05, 8, rx, oe_op); xfer(8'h00, 8, v, oe_dat); frame_close();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, v2, v3, rx;
    logic [3:0] oa, ob;
    logic [7:0] cfg;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check("R1 idle enables", io_oe, 0);
    rdsr(v, oa, ob);
    check("R1 reset status", v, 8'h00);
    check("R9 opcode-phase enables single", oa, 0);
    check("R9 data-phase enables single", ob, 4'b0010);
    check("R1 enables after frame", io_oe, 0);

    frame_open(); xfer(8'hA5, 8, rx, oa); xfer(8'h00, 8, rx, ob); frame_close();
    check("R10 unknown opcode no drive", ob, 0);
    rdsr(v, oa, ob);
    check("R10 unknown opcode status", v, 8'h00);

    cmd(8'h06); rdsr(v, oa, ob);
    check("R3 R4 set latch", v, 8'h02);
    cmd(8'hA5); rdsr(v, oa, ob);
    check("R10 unknown keeps latch", v, 8'h02);
    cmd(8'h04); rdsr(v, oa, ob);
    check("R4 clear latch", v, 8'h00);

    wrsr(8'hFF); rdsr(v, oa, ob);
    check("R6 write without latch", v, 8'h00);

    for (int d = 0; d < 256; d++) begin
      cmd(8'h06); wrsr(8'(d)); rdsr(v, oa, ob);
      check("R6 R7 R12 write sweep", v, d & 8'hBC);
    end
    cfg = 8'hBC & 8'hFF;

    frame_open(); xfer(8'h05, 8, rx, oa);
    xfer(8'h00, 8, v, ob); xfer(8'h00, 8, v2, ob); xfer(8'h00, 8, v3, ob);
    frame_close();
    check("R2 R5 repeat byte 1", v, cfg);
    check("R5 repeat byte 2", v2, cfg);
    check("R5 repeat byte 3", v3, cfg);

    cmd(8'h06);
    frame_open(); xfer(8'h01, 8, rx, oa); xfer(8'h00, 4, rx, oa); frame_close();
    rdsr(v, oa, ob);
    check("R6 R7 partial data byte", v, cfg);

    for (int k = 0; k < 3; k++) begin
      logic [7:0] op;
      op = (k == 0) ? 8'h02 : (k == 1) ? 8'h32 : 8'h12;
      cmd(8'h06);
      frame_open(); xfer(op, 8, rx, oa); xfer(8'h5A, 8, rx, oa); xfer(8'hC3, 8, rx, oa); frame_close();
      rdsr(v, oa, ob);
      check("R7 write-class clears latch", v, cfg);
    end

    frame_open(); xfer(8'hA0, 4, rx, oa); frame_close();
    cmd(8'h06); rdsr(v, oa, ob);
    check("R11 partial opcode discarded", v, cfg | 8'h02);
    cmd(8'h04);

    wrsr(8'h00);
    cmd(8'h06); wrsr(8'h00);
    cmd(8'h38); qm = 1'b1;
    rdsr(v, oa, ob);
    check("R8 quad flag set", v, 8'h40);
    check("R9 opcode-phase enables quad", oa, 0);
    check("R9 data-phase enables quad", ob, 4'hF);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d;
      d = 8'(i * 17) ^ 8'h40;
      cmd(8'h06); wrsr(d); rdsr(v, oa, ob);
      check("R8 R6 quad write sweep", v, (d & 8'hBC) | 8'h40);
    end
    cmd(8'h06); rdsr(v, oa, ob);
    check("R8 R4 quad latch", v, ((8'hFF ^ 8'h40) & 8'hBC) | 8'h42);
    cmd(8'hFF); qm = 1'b0;
    rdsr(v, oa, ob);
    check("R8 quad flag cleared", v, ((8'hFF ^ 8'h40) & 8'hBC) | 8'h02);
    check("R9 single enables again", ob, 4'b0010);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule